// File: doc/BRIEF.md
# Atomic Swap Memory Unit

The unit performs an indivisible exchange between a register value and one memory location. A requester hands it an address, a 32-bit store value, a byte/word size select and a flag saying whether the processor is in hypervisor mode. The unit reads the addressed location and then writes the store value to the same address. It returns the value it read. While the exchange runs, it keeps a lock line high so that an external arbiter holds every other master away from the location between the read and the write.

In word mode the whole word is exchanged. In byte mode the two low address bits pick a byte lane. Only that lane is written, and the read byte comes back zero-extended. A request made in hypervisor mode touches no memory and is answered with an undefined-instruction fault. One swap is handled at a time. The requester sees `req_ready` only while the unit is idle, and the result is delivered as a one-cycle pulse.

Top module: `atomic_swap_unit`

## Requirements
- R1: An accepted request issues a read (`mem_we`=0) and then a write (`mem_we`=1) to the same address. After the write is acknowledged, the value captured on the read acknowledge is returned on `rsp_rdata`.
- R2: In word mode (`req_byte`=0), both accesses drive `mem_be`=4'b1111. The write carries the full store value, and the full read word is returned.
- R3: In byte mode (`req_byte`=1), `mem_be` has only bit `addr[1:0]` set for both accesses. The low store byte is replicated on all four lanes of `mem_wdata`, and the other bytes of the word keep their old value.
- R4: In byte mode the result is the byte in lane `addr[1:0]` of the read data, zero-extended, so `rsp_rdata[31:8]` is 0.
- R5: `mem_lock` is high in every cycle in which `mem_req` is high. It stays high without a gap from the first read cycle through the write acknowledge.
- R6: A request accepted with `req_hyp`=1 drives no bus access. In the next cycle it produces `rsp_valid`=1 with `rsp_undef`=1 and `rsp_rdata`=0, and memory is left unchanged.
- R7: While `mem_req` is high and `mem_ack` is low, the next cycle keeps `mem_req`, `mem_we`, `mem_addr`, `mem_be`, `mem_wdata` and `mem_lock` unchanged.
- R8: The clock edge that samples the write acknowledge drops `mem_lock` and `mem_req`. In the following cycle `rsp_valid` is high for exactly one cycle.
- R9: `req_ready` is high only when no swap is in progress and no response is being delivered. A request held valid during the response cycle is taken only in the cycle after it.
- R10: A synchronous active-high `rst` returns the unit to idle with `mem_req`, `mem_lock` and `rsp_valid` low and `req_ready` high.
- R11: `mem_ack` has no effect while `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Swap request present |
| req_ready | output | 1 | Unit idle, request taken this cycle if valid |
| req_addr | input | ADDR_W | Byte address of the location |
| req_wdata | input | DATA_W | Value to store |
| req_byte | input | 1 | 1 = byte swap, 0 = word swap |
| req_hyp | input | 1 | Request issued in hypervisor mode |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_rdata | output | DATA_W | Old memory value (zero-extended in byte mode) |
| rsp_undef | output | 1 | Undefined-instruction fault flag |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Bus address |
| mem_be | output | DATA_W/8 | Byte lane enables |
| mem_wdata | output | DATA_W | Bus write data |
| mem_lock | output | 1 | Exclusive hold on the location |
| mem_ack | input | 1 | Bus access completed this cycle |
| mem_rdata | input | DATA_W | Bus read data, valid with `mem_ack` |

## Verification
Two coincidences matter most. The first is the write acknowledge landing in the same cycle as a request that is already waiting: the lock has to drop and the response has to pulse, and the waiting request must not slip in until the cycle after. The bench provokes this by holding `req_valid` high across whole chains of swaps. The second is an acknowledge arriving in the very first cycle of the read, so that the read phase and the switch to the write phase share that cycle. The bench provokes it with a zero-wait memory, and it also runs a memory that stalls at random and pulses `mem_ack` even when nothing is requested. In both cases a behavioural model of the exchange predicts every port on every clock, and directed swaps compare returned values with constants worked out by hand.

// File: rtl/swap_pkg.sv
package swap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } swap_state_e;

    localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/swap_lane_unit.sv
// Byte-lane steering: enables, store replication and load extraction.
module swap_lane_unit
    import swap_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                         byte_mode,
    input  logic [$clog2(DATA_W/LANE_BITS)-1:0] lane_sel,
    input  logic [DATA_W-1:0]            store_val,
    input  logic [DATA_W-1:0]            load_word,
    output logic [DATA_W/LANE_BITS-1:0]  lane_en,
    output logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            load_result
);
    localparam int unsigned LANES = DATA_W / LANE_BITS;

    logic [LANE_BITS-1:0] lane_byte [LANES];
    logic [LANES-1:0]     sel_hot;
    logic [LANE_BITS-1:0] picked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = load_word[g*LANE_BITS +: LANE_BITS];
        assign sel_hot[g]   = (lane_sel == g[$clog2(LANES)-1:0]);
        assign lane_en[g]   = byte_mode ? sel_hot[g] : 1'b1;
        assign bus_wdata[g*LANE_BITS +: LANE_BITS] =
            byte_mode ? store_val[LANE_BITS-1:0]
                      : store_val[g*LANE_BITS +: LANE_BITS];
    end

    always_comb begin
        picked = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel_hot[i]) picked = lane_byte[i];
        end
    end

    always_comb begin
        if (byte_mode) begin
            load_result = '0;
            load_result[LANE_BITS-1:0] = picked;
        end else begin
            load_result = load_word;
        end
    end

endmodule

// File: rtl/swap_seq.sv
// Sequencer: accept, locked read, locked write, one-cycle response.
module swap_seq
    import swap_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_byte,
    input  logic              req_hyp,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] load_result,
    output swap_state_e       state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              byte_o,
    output logic              lock_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              undef_o
);
    typedef struct packed {
        swap_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              bmode;
        logic              lock;
        logic [DATA_W-1:0] rdata;
        logic              undef;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_hyp) begin
                        seq_d.st    = ST_RESP;
                        seq_d.undef = 1'b1;
                        seq_d.rdata = '0;
                    end else begin
                        seq_d.st    = ST_READ;
                        seq_d.addr  = req_addr;
                        seq_d.wdata = req_wdata;
                        seq_d.bmode = req_byte;
                        seq_d.lock  = 1'b1;
                        seq_d.undef = 1'b0;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    seq_d.rdata = load_result;
                    seq_d.st    = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    seq_d.st   = ST_RESP;
                    seq_d.lock = 1'b0;
                end
            end
            ST_RESP: begin
                seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.st;
    assign addr_o  = seq_q.addr;
    assign wdata_o = seq_q.wdata;
    assign byte_o  = seq_q.bmode;
    assign lock_o  = seq_q.lock;
    assign rdata_o = seq_q.rdata;
    assign undef_o = seq_q.undef;

endmodule

// File: rtl/atomic_swap_unit.sv
module atomic_swap_unit
    import swap_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    input  logic                        req_byte,
    input  logic                        req_hyp,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata,
    output logic                        rsp_undef,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W/LANE_BITS-1:0] mem_be,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic                        mem_lock,
    input  logic                        mem_ack,
    input  logic [DATA_W-1:0]           mem_rdata
);
    localparam int unsigned LANES  = DATA_W / LANE_BITS;
    localparam int unsigned LSEL_W = $clog2(LANES);

    swap_state_e       state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              byte_q;
    logic              lock_q;
    logic [DATA_W-1:0] rdata_q;
    logic              undef_q;
    logic [DATA_W-1:0] load_result;

    swap_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_byte   (req_byte),
        .req_hyp    (req_hyp),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_ack    (mem_ack),
        .load_result(load_result),
        .state_o    (state),
        .addr_o     (addr_q),
        .wdata_o    (wdata_q),
        .byte_o     (byte_q),
        .lock_o     (lock_q),
        .rdata_o    (rdata_q),
        .undef_o    (undef_q)
    );

    swap_lane_unit #(.DATA_W(DATA_W)) u_lane (
        .byte_mode  (byte_q),
        .lane_sel   (addr_q[LSEL_W-1:0]),
        .store_val  (wdata_q),
        .load_word  (mem_rdata),
        .lane_en    (mem_be),
        .bus_wdata  (mem_wdata),
        .load_result(load_result)
    );

    assign req_ready = (state == ST_IDLE);
    assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = addr_q;
    assign mem_lock  = lock_q;
    assign rsp_valid = (state == ST_RESP);
    assign rsp_rdata = rdata_q;
    assign rsp_undef = undef_q;

endmodule

// File: rtl/swap_checker.sv
module swap_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_hyp,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_undef,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W/8-1:0] mem_be,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_lock,
    input logic              mem_ack
);
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && $stable(mem_addr))); // R1

    AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($countones(mem_be) == 1 || mem_be == '1)); // R3

    AST_LOCK_COVERS_BUS: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock); // R5

    AST_HYP_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_hyp) |=> (rsp_valid && rsp_undef && !mem_req && rsp_rdata == '0)); // R6

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && mem_lock && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_be) && $stable(mem_wdata))); // R7

    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> (!mem_lock && !mem_req && rsp_valid)); // R8

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (mem_req || rsp_valid) |-> !req_ready); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!mem_req && !mem_lock && !rsp_valid && req_ready)); // R10

    AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid) |=> req_ready); // R11
endmodule

bind atomic_swap_unit swap_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_hyp  (req_hyp),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_undef(rsp_undef),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .mem_wdata(mem_wdata),
    .mem_lock (mem_lock),
    .mem_ack  (mem_ack)
);

// File: tb/tb_atomic_swap_unit.sv
`timescale 1ns/1ps
module tb_atomic_swap_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_byte = 1'b0;
    logic        req_hyp = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_undef;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_lock;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    atomic_swap_unit dut (.*);

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;
    int ack_mode = 0;   // 0: ack always, 1: random stalls plus stray acks
    logic [15:0] lfsr = 16'hACE1;

    logic [31:0] bmem [16];

    // Behavioural reference of the exchange
    int          ms = 0;
    logic [31:0] m_addr = '0, m_wd = '0, m_rd = '0;
    bit          m_byte = 0, m_undef = 0;

    always @(posedge clk) begin
        int lane;
        int idx;
        started = 1;
        if (rst) begin
            ms = 0; m_undef = 0; m_rd = '0;
        end else begin
            lane = int'(m_addr[1:0]);
            idx  = int'(m_addr[5:2]);
            case (ms)
                0: if (req_valid) begin
                    if (req_hyp) begin ms = 3; m_undef = 1; m_rd = '0; end
                    else begin
                        ms = 1; m_addr = req_addr; m_wd = req_wdata;
                        m_byte = req_byte; m_undef = 0;
                    end
                end
                1: if (mem_ack) begin
                    m_rd = m_byte ? ((mem_rdata >> (8*lane)) & 32'hFF) : mem_rdata;
                    ms = 2;
                end
                2: if (mem_ack) begin
                    if (m_byte) bmem[idx][lane*8 +: 8] = m_wd[7:0];
                    else bmem[idx] = m_wd;
                    ms = 3;
                end
                default: ms = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison and memory model drive, away from the active edge
    always @(negedge clk) begin
        logic [3:0]  e_be;
        logic [31:0] e_wd;
        if (started && !finished) begin
            chk(req_ready == (ms == 0), "R9 req_ready", {31'b0, req_ready}, {31'b0, ms == 0});
            chk(mem_req == (ms == 1 || ms == 2), "R1 mem_req", {31'b0, mem_req}, {31'b0, ms == 1 || ms == 2});
            chk(mem_lock == (ms == 1 || ms == 2), "R5 mem_lock", {31'b0, mem_lock}, {31'b0, ms == 1 || ms == 2});
            chk(rsp_valid == (ms == 3), "R8 rsp_valid", {31'b0, rsp_valid}, {31'b0, ms == 3});
            if (ms == 1 || ms == 2) begin
                e_be = m_byte ? (4'b0001 << m_addr[1:0]) : 4'b1111;
                chk(mem_we == (ms == 2), "R1 mem_we", {31'b0, mem_we}, {31'b0, ms == 2});
                chk(mem_addr == m_addr, "R1 mem_addr", mem_addr, m_addr);
                chk(mem_be == e_be, "R3 mem_be", {28'b0, mem_be}, {28'b0, e_be});
                if (ms == 2) begin
                    e_wd = m_byte ? {4{m_wd[7:0]}} : m_wd;
                    chk(mem_wdata == e_wd, "R3 mem_wdata", mem_wdata, e_wd);
                end
            end
            if (ms == 3) begin
                chk(rsp_rdata == m_rd, "R4 rsp_rdata", rsp_rdata, m_rd);
                chk(rsp_undef == m_undef, "R6 rsp_undef", {31'b0, rsp_undef}, {31'b0, m_undef});
            end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ack   = (ack_mode == 0) ? mem_req : (lfsr[0] | lfsr[2]);  // R11 stray acks
        mem_rdata = bmem[mem_addr[5:2]];
    end

    task automatic do_swap(input logic [31:0] a, input logic [31:0] d, input bit b, input bit h,
                           input logic [31:0] exp_rd, input bit exp_undef, input string req);
        @(negedge clk);
        req_addr = a; req_wdata = d; req_byte = b; req_hyp = h; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk(rsp_rdata == exp_rd, req, rsp_rdata, exp_rd);
        chk(rsp_undef == exp_undef, req, {31'b0, rsp_undef}, {31'b0, exp_undef});
    endtask

    initial begin
        for (int i = 0; i < 16; i++) bmem[i] = 32'h10203040 + i * 32'h01010101;
        req_valid = 1'b1;   // ignored under reset (R10)
        repeat (4) @(negedge clk);
        chk(!mem_req && !mem_lock && !rsp_valid, "R10 idle in reset", {29'b0, mem_req, mem_lock, rsp_valid}, 32'h0);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", {31'b0, req_ready}, 32'h1);

        // Zero-wait memory: ack in the first cycle of each phase
        ack_mode = 0;
        do_swap(32'h04, 32'hAABBCCDD, 0, 0, 32'h11213141, 0, "R2 word swap old value");
        do_swap(32'h04, 32'h00000000, 0, 0, 32'hAABBCCDD, 0, "R1 second swap sees stored word");
        do_swap(32'h06, 32'hFFFFFF5A, 1, 0, 32'h00000000, 0, "R4 byte lane2 of zero word");
        do_swap(32'h06, 32'h00000077, 1, 0, 32'h0000005A, 0, "R4 byte zero-extended");
        do_swap(32'h04, 32'h00000000, 0, 0, 32'h00770000, 0, "R3 only lane2 written");

        // Stalling memory with stray acks
        ack_mode = 1;
        do_swap(32'h0B, 32'h00000099, 1, 0, 32'h00000012, 0, "R4 byte lane3");
        do_swap(32'h08, 32'h00000000, 0, 0, 32'h99223242, 0, "R3 lane3 merged");
        do_swap(32'h0C, 32'h000000E1, 1, 0, 32'h00000043, 0, "R4 byte lane0");
        do_swap(32'h0C, 32'h00000055, 0, 1, 32'h00000000, 1, "R6 hyp faults");
        do_swap(32'h0C, 32'h00000000, 0, 0, 32'h132333E1, 0, "R6 memory untouched by hyp");

        // Request held valid through responses (R9), both ack modes
        for (int m = 0; m < 2; m++) begin
            ack_mode = m;
            @(negedge clk);
            req_addr = 32'h10 + m * 4; req_wdata = 32'hC0DE0000 + m; req_byte = 0; req_hyp = 0;
            req_valid = 1'b1;
            repeat (60) @(negedge clk);
            req_byte = 1; req_addr = 32'h13;
            repeat (60) @(negedge clk);
            req_valid = 1'b0;
            repeat (12) @(negedge clk);
        end

        // Idle with stray acks (R11)
        ack_mode = 1;
        repeat (30) @(negedge clk);
        chk(!mem_req && req_ready, "R11 stray ack ignored", {30'b0, mem_req, req_ready}, 32'h1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule